// File: doc/BRIEF.md
# IEEE-488 Listener Acceptor Handshake

This block is the listener side of an IEEE-488 instrument port. It watches the active-low bus lines ATN, DAV, REN and DIO1–DIO8 and drives NDAC and NRFD. Those two outputs are open-drain on the bus, so here they are modelled as output enables: 1 pulls the line low. Every bus input first passes through a two-flop synchronizer.

The hardware does not run the handshake on its own. When the controller presents a byte and asserts DAV, the block captures the byte, pulls NRFD and raises an interrupt. The embedded processor then reads a status word and the data byte. After that it writes a small control latch. One bit releases NDAC to signal that the byte was accepted, another releases NRFD to signal that the next byte can come, and a third lets plain data bytes in when ATN is false.

Command bytes (ATN true) are always taken. Asserting ATN engages NDAC at once, with no processor action.

Top module: `gpib_acceptor`

## Requirements
- R1: Bus inputs are true when low. Status bit 5 equals the inverted, synchronized REN line. The captured byte is the bit-wise inverse of the DIO lines (DIO1 on bit 0).
- R2: Within 3 clocks of ATN going low, ndac_oe is 1, with no processor write. A rising ATN also clears the accept latch.
- R3: With ATN false and the listen latch (control bit 2) at 0, a DAV assertion is ignored. irq stays 0, data_out is unchanged, and ndac_oe and nrfd_oe stay 0.
- R4: When a qualified DAV assertion arrives (ATN true, or listen latch set), the block acts within 4 clocks. irq goes to 1, status bit 3 is set, status bit 6 equals ATN, status bit 0 mirrors irq, and nrfd_oe goes to 1 because the ready latch is cleared.
- R5: data_out holds the last captured byte. A one-cycle rd_data pulse clears irq. irq does not rise again while DAV stays true.
- R6: A wr_ctrl pulse loads wr_data into the latches: bit 0 accept, bit 1 ready, bit 2 listen. While the block is engaged (ATN true or listen set), ndac_oe is the inverse of accept and nrfd_oe is the inverse of ready. When it is not engaged, both outputs are 0.
- R7: When DAV returns false, the accept latch clears, so ndac_oe returns to 1 if the block is engaged. Status bit 3 also clears.
- R8: A synchronous reset releases both outputs, clears irq, zeroes all latches and returns the synchronizers to the released level. Status is then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| atn_n | input | 1 | Attention bus line, low true |
| dav_n | input | 1 | Data valid bus line, low true |
| ren_n | input | 1 | Remote enable bus line, low true |
| dio_n | input | 8 | Data bus lines, low true |
| ndac_oe | output | 1 | 1 pulls NDAC low |
| nrfd_oe | output | 1 | 1 pulls NRFD low |
| irq | output | 1 | Interrupt request to the processor |
| status | output | 8 | Bit 0 irq, bit 3 byte held, bit 5 remote, bit 6 command |
| data_out | output | 8 | Last captured byte |
| rd_data | input | 1 | Data-byte read strobe, clears irq |
| wr_ctrl | input | 1 | Control latch write strobe |
| wr_data | input | 3 | Latch value: bit 0 accept, bit 1 ready, bit 2 listen |

## Verification
The bench mixes random command and data bytes with the listen latch toggled at random. A design that lets data bytes through without the listen latch would raise a spurious interrupt and overwrite data_out.

The bench keeps DAV held after the byte is read. A level-triggered design would raise the interrupt a second time.

It checks that NDAC is pulled as soon as ATN goes true, before any write. It also checks that NDAC is pulled again when DAV drops. A design missing either step would let the controller run ahead.

A reset applied in the middle of a transfer must release both lines even while ATN is still asserted.

// File: rtl/gpib_acceptor.sv
module gpib_acceptor #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          atn_n,
  input  logic          dav_n,
  input  logic          ren_n,
  input  logic [DW-1:0] dio_n,
  output logic          ndac_oe,
  output logic          nrfd_oe,
  output logic          irq,
  output logic [7:0]    status,
  output logic [DW-1:0] data_out,
  input  logic          rd_data,
  input  logic          wr_ctrl,
  input  logic [2:0]    wr_data
);
  logic [1:0]    atn_sy, dav_sy, ren_sy;
  logic [DW-1:0] dio_s1, dio_s2;
  logic          atn_q, dav_q;
  logic          lat_accept, lat_ready, lat_listen;
  logic          irq_r, held, cmd_r;
  logic [DW-1:0] byte_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      atn_sy <= '1; dav_sy <= '1; ren_sy <= '1;
      dio_s1 <= '1; dio_s2 <= '1;
      atn_q  <= 1'b0; dav_q <= 1'b0;
    end else begin
      atn_sy <= {atn_sy[0], atn_n};
      dav_sy <= {dav_sy[0], dav_n};
      ren_sy <= {ren_sy[0], ren_n};
      dio_s1 <= dio_n;
      dio_s2 <= dio_s1;
      atn_q  <= ~atn_sy[1];
      dav_q  <= ~dav_sy[1];
    end
  end

  wire atn_t    = ~atn_sy[1];
  wire dav_t    = ~dav_sy[1];
  wire ren_t    = ~ren_sy[1];
  wire engaged  = atn_t | lat_listen;
  wire capture  = dav_t & ~dav_q & engaged;
  wire dav_drop = ~dav_t & dav_q;
  wire atn_rise = atn_t & ~atn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_accept <= 1'b0; lat_ready <= 1'b0; lat_listen <= 1'b0;
      irq_r <= 1'b0; held <= 1'b0; cmd_r <= 1'b0; byte_r <= '0;
    end else begin
      if (wr_ctrl) {lat_listen, lat_ready, lat_accept} <= wr_data;
      if (capture) begin
        byte_r    <= ~dio_s2;
        cmd_r     <= atn_t;
        held      <= 1'b1;
        irq_r     <= 1'b1;
        lat_ready <= 1'b0;
      end else if (rd_data) begin
        irq_r <= 1'b0;
      end
      if (dav_drop) begin
        held       <= 1'b0;
        lat_accept <= 1'b0;
      end
      if (atn_rise) lat_accept <= 1'b0;
    end
  end

  assign ndac_oe  = engaged & ~lat_accept;
  assign nrfd_oe  = engaged & ~lat_ready;
  assign irq      = irq_r;
  assign data_out = byte_r;
  assign status   = {1'b0, cmd_r, ren_t, 1'b0, held, 2'b00, irq_r};
endmodule

module gpib_acceptor_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq,
  input logic       ndac_oe,
  input logic       nrfd_oe,
  input logic       rd_data,
  input logic [7:0] status
);
  // R8
  reset_release_chk: assert property (@(posedge clk)
    rst |=> (!irq && !ndac_oe && !nrfd_oe));

  // R5
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(irq) && !$past(rst)) |-> $past(rd_data));

  // R4
  irq_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq) && !$past(rst)) |-> status[3]);

  // R4
  irq_nrfd_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq) && !$past(rst)) |-> nrfd_oe);
endmodule

bind gpib_acceptor gpib_acceptor_chk u_chk (
  .clk(clk), .rst(rst), .irq(irq), .ndac_oe(ndac_oe),
  .nrfd_oe(nrfd_oe), .rd_data(rd_data), .status(status)
);

// File: tb/gpib_acceptor_bench.sv
module gpib_acceptor_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic atn_n = 1'b1, dav_n = 1'b1, ren_n = 1'b1;
  logic [7:0] dio_n = 8'hFF;
  logic rd_data = 1'b0, wr_ctrl = 1'b0;
  logic [2:0] wr_data = 3'b000;
  logic ndac_oe, nrfd_oe, irq;
  logic [7:0] status, data_out;

  int checks = 0;
  int fails  = 0;

  bit m_acc, m_rdy, m_lis, m_atn;
  logic [7:0] m_byte;

  always #2 clk = ~clk;

  gpib_acceptor u_gpib_acceptor (
    .clk(clk), .rst(rst), .atn_n(atn_n), .dav_n(dav_n), .ren_n(ren_n),
    .dio_n(dio_n), .ndac_oe(ndac_oe), .nrfd_oe(nrfd_oe), .irq(irq),
    .status(status), .data_out(data_out), .rd_data(rd_data),
    .wr_ctrl(wr_ctrl), .wr_data(wr_data)
  );

  function automatic bit exp_ndac();
    return (m_atn | m_lis) & ~m_acc;
  endfunction

  function automatic bit exp_nrfd();
    return (m_atn | m_lis) & ~m_rdy;
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [2:0] v);
    wr_ctrl = 1'b1; wr_data = v;
    step(1);
    wr_ctrl = 1'b0;
    {m_lis, m_rdy, m_acc} = v;
  endtask

  task automatic read_data();
    rd_data = 1'b1;
    step(1);
    rd_data = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0488));
    m_byte = 8'h00;
    step(3);
    rst = 1'b0;
    step(1);
    // R8 reset state
    chk("R8 ndac", ndac_oe, 0);
    chk("R8 nrfd", nrfd_oe, 0);
    chk("R8 irq", irq, 0);
    chk("R8 status", status, 8'h00);

    // R2 ATN alone pulls NDAC
    atn_n = 1'b0; m_atn = 1;
    step(3);
    chk("R2 ndac on atn", ndac_oe, 1);
    chk("R6 nrfd not ready", nrfd_oe, 1);
    atn_n = 1'b1; m_atn = 0;
    step(3);
    chk("R6 released when idle", ndac_oe, 0);

    for (int i = 0; i < 60; i++) begin
      bit a, l, r, q;
      logic [7:0] b;
      a = ($urandom % 2) == 1;
      l = ($urandom % 2) == 1;
      r = ($urandom % 2) == 1;
      b = 8'($urandom);
      if (i == 0) begin a = 0; l = 0; end
      if (i == 1) begin a = 1; b = 8'h00; end
      if (i == 2) begin a = 0; l = 1; b = 8'hFF; end
      write_ctrl({l, 1'b1, 1'b0});
      if (a && !m_atn) m_acc = 0;
      atn_n = ~a; m_atn = a; ren_n = ~r; dio_n = ~b;
      step(4);
      chk("R2 ndac engaged", ndac_oe, exp_ndac());
      chk("R6 nrfd ready", nrfd_oe, exp_nrfd());
      chk("R1 remote bit", status[5], r);
      q = a | l;
      dav_n = 1'b0;
      step(4);
      if (q) begin
        m_rdy = 0; m_byte = b;
        chk("R4 irq", irq, 1);
        chk("R4 held bit", status[3], 1);
        chk("R4 cmd bit", status[6], a);
        chk("R4 irq bit", status[0], 1);
        chk("R4 nrfd pulled", nrfd_oe, 1);
      end else begin
        chk("R3 no irq", irq, 0);
        chk("R3 no held", status[3], 0);
        chk("R3 ndac", ndac_oe, 0);
        chk("R3 nrfd", nrfd_oe, 0);
      end
      read_data();
      chk("R1 R5 data byte", data_out, m_byte);
      chk("R5 irq cleared", irq, 0);
      step(3);
      chk("R5 no refire", irq, 0);
      write_ctrl({l, 1'b0, 1'b1});
      chk("R6 ndac accepted", ndac_oe, exp_ndac());
      chk("R6 nrfd", nrfd_oe, exp_nrfd());
      dav_n = 1'b1;
      step(4);
      m_acc = 0;
      chk("R7 ndac reassert", ndac_oe, exp_ndac());
      chk("R7 held cleared", status[3], 0);
    end

    // R8 reset mid-transfer
    write_ctrl(3'b110);
    atn_n = 1'b0; dio_n = 8'h5A;
    step(4);
    dav_n = 1'b0;
    step(4);
    chk("R4 before reset", irq, 1);
    rst = 1'b1;
    step(1);
    chk("R8 irq", irq, 0);
    chk("R8 ndac", ndac_oe, 0);
    chk("R8 nrfd", nrfd_oe, 0);
    atn_n = 1'b1; dav_n = 1'b1; ren_n = 1'b1;
    step(2);
    rst = 1'b0;
    step(3);
    chk("R8 status after", status, 8'h00);
    chk("R8 latches zeroed", ndac_oe, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule